// File: doc/BRIEF.md
# Three-Phase PWM Generator with Emergency Stop

The block drives three complementary output pairs (phases U, V and W) from one up-counting period counter. The counter runs from zero up to a programmable period value and then wraps to zero, so one PWM period lasts period+1 clock cycles. Each phase has its own compare value, and its high-side output is active while the counter is below that compare value. Its low-side output is always the opposite level. Each pair has a polarity bit that inverts both of its outputs.

An active-low emergency input stops the outputs. When it is asserted and not blocked, all six outputs are forced to 0 and held there. To restart, software writes a key value to the emergency register, and this write is only accepted once the pin has returned to its inactive level. After a restart the pin is not monitored. Detection comes back into force when a second write of zero re-arms it. A block bit in the control register cuts the pin off entirely. Software reaches all of this through a simple write port made of an address, data and a strobe.

Top module: `pwm3_top`

## Requirements
- R1: The counter counts 0,1,...,P and then returns to 0, where P is the period register (address 0). In every window of P+1 consecutive cycles, a phase high-side output is 1 for exactly min(C, P+1) cycles, where C is that phase's compare register (addresses 1, 2 and 3 for U, V and W).
- R2: A compare value greater than P holds the high-side output at 1 (polarity 0) for the whole period.
- R3: A compare value of 0 holds the high-side output at 0 (polarity 0) for the whole period.
- R4: Outside an emergency stop, each low-side output is the complement of its high-side output on every cycle, including both held cases.
- R5: The control register (address 4) holds the polarity bits in bits 0, 1 and 2, for U, V and W. A set bit inverts both outputs of its pair.
- R6: A low level on estop_n, while detection is armed and not blocked, drives all six outputs to 0 by the fourth clock edge. The outputs stay at 0 after the pin returns high.
- R7: Writing 0x4321 to the emergency register (address 5) while stopped restarts the outputs. The write is ignored while the synchronized pin is still low.
- R8: After a restart the pin has no effect until 0x0000 is written to the emergency register. After that write, a low pin stops the outputs again.
- R9: When bit 6 of the control register is set, the emergency pin has no effect.
- R10: After reset, all registers are 0 and detection is armed, so pwm_hi is 000 and pwm_lo is 111.
- R11: While stopped, a write of any value other than 0x4321 to the emergency register leaves the outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| estop_n | input | 1 | Emergency stop input, active low, asynchronous |
| pwm_hi | output | 3 | High-side outputs, bit 0 = U, 1 = V, 2 = W |
| pwm_lo | output | 3 | Low-side outputs, same bit order |

## Verification
A register write takes effect at the clock edge that samples the strobe. Every output is registered, so it shows the counter state of the previous cycle. An edge on the emergency pin reaches the outputs at the fourth rising edge: two synchronizer stages, the stop state, and then the output register. The bench therefore waits six or more cycles after any pin change or key write before it samples. For duty cycle, it first lets at least two whole periods settle, then counts high cycles over a window of exactly P+1 consecutive falling edges. That count does not depend on where the window starts.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    localparam int NPH = 3;

    localparam int A_PERIOD = 0;
    localparam int A_CMP0   = 1;
    localparam int A_CTRL   = 4;
    localparam int A_ESTOP  = 5;

    localparam int BLOCK_BIT = 6;

    localparam logic [15:0] KEY_RESTART = 16'h4321;
    localparam logic [15:0] KEY_REARM   = 16'h0000;

    typedef enum logic [1:0] {
        EST_ARMED = 2'd0,
        EST_TRIP  = 2'd1,
        EST_FREE  = 2'd2
    } est_e;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [CNT_W-1:0]          period,
    output logic [NPH-1:0][CNT_W-1:0] cmp,
    output logic [NPH-1:0]            pol,
    output logic                      block
);
    typedef struct packed {
        logic [CNT_W-1:0]          period;
        logic [NPH-1:0][CNT_W-1:0] cmp;
        logic [NPH-1:0]            pol;
        logic                      block;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(A_PERIOD))
                r_d.period = wr_data[CNT_W-1:0];
            for (int i = 0; i < NPH; i++) begin
                if (wr_addr == ADDR_W'(A_CMP0 + i))
                    r_d.cmp[i] = wr_data[CNT_W-1:0];
            end
            if (wr_addr == ADDR_W'(A_CTRL)) begin
                r_d.pol   = wr_data[NPH-1:0];
                r_d.block = wr_data[BLOCK_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign period = r_q.period;
    assign cmp    = r_q.cmp;
    assign pol    = r_q.pol;
    assign block  = r_q.block;
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (c_q.cnt >= period) c_d.cnt = '0;
        else                   c_d.cnt = c_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign cnt = c_q.cnt;
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             pol,
    input  logic             stop,
    output logic             hi,
    output logic             lo
);
    typedef struct packed {
        logic hi;
        logic lo;
    } pair_t;

    pair_t p_d, p_q;
    logic  raw;

    always_comb begin
        raw = (cnt < cmp);
        p_d = p_q;
        if (stop) begin
            p_d.hi = 1'b0;
            p_d.lo = 1'b0;
        end else begin
            p_d.hi = raw ^ pol;
            p_d.lo = ~raw ^ pol;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '{hi: 1'b0, lo: 1'b1};
        else     p_q <= p_d;
    end

    assign hi = p_q.hi;
    assign lo = p_q.lo;
endmodule

// File: rtl/pwm3_estop.sv
module pwm3_estop
    import pwm3_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              estop_n,
    input  logic              block,
    output logic              pin_act,
    output logic              stop
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        est_e                   st;
    } est_t;

    est_t e_d, e_q;
    logic esc_wr;
    logic pin_eff;

    always_comb begin
        esc_wr  = wr_en && (wr_addr == ADDR_W'(A_ESTOP));
        pin_eff = e_q.sync[SYNC_STAGES-1] && !block;
        e_d      = e_q;
        e_d.sync = {e_q.sync[SYNC_STAGES-2:0], ~estop_n};
        case (e_q.st)
            EST_ARMED: if (pin_eff) e_d.st = EST_TRIP;
            EST_TRIP:  if (esc_wr && wr_data == DATA_W'(KEY_RESTART) && !pin_eff)
                           e_d.st = EST_FREE;
            EST_FREE:  if (esc_wr && wr_data == DATA_W'(KEY_REARM))
                           e_d.st = EST_ARMED;
            default:   e_d.st = EST_TRIP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '{sync: '0, st: EST_ARMED};
        else     e_q <= e_d;
    end

    assign pin_act = e_q.sync[SYNC_STAGES-1];
    assign stop    = (e_q.st == EST_TRIP);
endmodule

// File: rtl/pwm3_top.sv
module pwm3_top
    import pwm3_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              estop_n,
    output logic [NPH-1:0]    pwm_hi,
    output logic [NPH-1:0]    pwm_lo
);
    logic [CNT_W-1:0]          period_w;
    logic [NPH-1:0][CNT_W-1:0] cmp_w;
    logic [NPH-1:0]            pol_w;
    logic                      block_w;
    logic [CNT_W-1:0]          cnt_w;
    logic                      pin_act_w;
    logic                      stop_w;

    pwm3_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .period(period_w), .cmp(cmp_w), .pol(pol_w), .block(block_w)
    );

    pwm3_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .period(period_w), .cnt(cnt_w)
    );

    pwm3_estop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_est (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .estop_n(estop_n), .block(block_w), .pin_act(pin_act_w), .stop(stop_w)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_ph
        pwm3_phase #(.CNT_W(CNT_W)) u_ph (
            .clk(clk), .rst(rst), .cnt(cnt_w), .cmp(cmp_w[g]), .pol(pol_w[g]),
            .stop(stop_w), .hi(pwm_hi[g]), .lo(pwm_lo[g])
        );
    end
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk #(
    parameter int CNT_W = 16,
    parameter int NPH   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [NPH-1:0]   pwm_hi,
    input logic [NPH-1:0]   pwm_lo,
    input logic [CNT_W-1:0] cnt_w,
    input logic [CNT_W-1:0] period_w,
    input logic             stop_w,
    input logic             pin_act_w,
    input logic             block_w
);
    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_w >= period_w) |=> (cnt_w == '0));

    // R4
    complement_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(stop_w) |-> ((pwm_hi ^ pwm_lo) == '1));

    // R6
    safe_state_chk: assert property (@(posedge clk) disable iff (rst)
        stop_w |=> (pwm_hi == '0 && pwm_lo == '0));

    // R7
    hold_while_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_w && pin_act_w && !block_w) |=> stop_w);

    // R9
    blocked_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (block_w && !stop_w) |=> !stop_w);
endmodule

bind pwm3_top pwm3_chk #(.CNT_W(CNT_W), .NPH(pwm3_pkg::NPH)) u_chk (
    .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .cnt_w(cnt_w),
    .period_w(period_w), .stop_w(stop_w), .pin_act_w(pin_act_w), .block_w(block_w)
);

// File: tb/tb_pwm3_top.sv
`timescale 1ns/1ps
module tb_pwm3_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        estop_n = 1'b1;
    logic [2:0]  pwm_hi, pwm_lo;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pwm3_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .estop_n(estop_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    localparam int NV = 8;
    localparam int TP  [NV] = '{7, 7, 7, 7,   7, 4, 9, 0};
    localparam int TC  [NV] = '{3, 0, 8, 200, 7, 2, 5, 1};
    localparam int TPOL[NV] = '{0, 0, 0, 0,   0, 1, 1, 0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n, output int hu, output int hv, output int hw,
                           output int bad, output int nz);
        hu = 0; hv = 0; hw = 0; bad = 0; nz = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hu += int'(pwm_hi[0]); hv += int'(pwm_hi[1]); hw += int'(pwm_hi[2]);
            if ((pwm_hi ^ pwm_lo) != 3'b111) bad++;
            if (pwm_hi != 3'b000 || pwm_lo != 3'b000) nz++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int hu, hv, hw, bad, nz, m, eu;
        idle(4);
        rst = 1'b0;

        // R10: reset state
        measure(4, hu, hv, hw, bad, nz);
        check(pwm_hi == 3'b000 && hu + hv + hw == 0, "R10 hi after reset", int'(pwm_hi), 0);
        check(pwm_lo == 3'b111 && bad == 0, "R10 lo after reset", int'(pwm_lo), 7);

        // Table walk: R1, R2, R3, R4, R5
        for (int v = 0; v < NV; v++) begin
            wr(0, TP[v]);
            wr(1, TC[v]); wr(2, TC[v]); wr(3, 0);
            wr(4, TPOL[v] != 0 ? 7 : 0);
            idle(2 * (TP[v] + 1) + 4);
            measure(TP[v] + 1, hu, hv, hw, bad, nz);
            m  = (TC[v] < TP[v] + 1) ? TC[v] : TP[v] + 1;
            eu = (TPOL[v] != 0) ? (TP[v] + 1 - m) : m;
            check(hu == eu && hv == eu, "R1/R2/R5 duty U,V", hu, eu);
            check(hw == ((TPOL[v] != 0) ? TP[v] + 1 : 0), "R3/R5 zero compare W", hw,
                  (TPOL[v] != 0) ? TP[v] + 1 : 0);
            check(bad == 0, "R4 complement", bad, 0);
        end

        // Base setup for emergency tests: P=7, C=4, polarity 0
        wr(0, 7); wr(1, 4); wr(2, 4); wr(3, 4); wr(4, 0);
        idle(20);

        // R6: trip and latch
        estop_n = 1'b0; idle(6);
        measure(8, hu, hv, hw, bad, nz);
        check(nz == 0, "R6 outputs safe on trip", nz, 0);
        estop_n = 1'b1; idle(6);
        measure(8, hu, hv, hw, bad, nz);
        check(nz == 0, "R6 stays stopped after release", nz, 0);

        // R7: key ignored while pin low
        estop_n = 1'b0; idle(6);
        wr(5, 16'h4321); idle(6);
        measure(8, hu, hv, hw, bad, nz);
        check(nz == 0, "R7 key ignored with pin low", nz, 0);

        // R11: wrong value ignored
        estop_n = 1'b1; idle(6);
        wr(5, 16'h1234); idle(6);
        measure(8, hu, hv, hw, bad, nz);
        check(nz == 0, "R11 wrong key ignored", nz, 0);

        // R7: valid restart
        wr(5, 16'h4321); idle(20);
        measure(8, hu, hv, hw, bad, nz);
        check(hu == 4 && bad == 0, "R7 restart runs", hu, 4);

        // R8: unarmed after restart
        estop_n = 1'b0; idle(6);
        measure(8, hu, hv, hw, bad, nz);
        check(hu == 4 && bad == 0, "R8 pin ignored before rearm", hu, 4);
        estop_n = 1'b1; idle(6);
        wr(5, 0); idle(4);
        estop_n = 1'b0; idle(6);
        measure(8, hu, hv, hw, bad, nz);
        check(nz == 0, "R8 rearmed pin trips", nz, 0);

        // recover
        estop_n = 1'b1; idle(6);
        wr(5, 16'h4321); wr(5, 0); idle(20);

        // R9: block bit
        wr(4, 16'h0040); idle(2);
        estop_n = 1'b0; idle(8);
        measure(8, hu, hv, hw, bad, nz);
        check(hu == 4 && bad == 0, "R9 blocked pin no effect", hu, 4);
        estop_n = 1'b1; idle(6);
        wr(4, 0); idle(6);
        measure(8, hu, hv, hw, bad, nz);
        check(hu == 4 && bad == 0, "R9 running after unblock", hu, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule